// File: doc/BRIEF.md
# Threshold-Triggered Burst FIFO

This block sits between the producer side and the memory side of a DMA channel. Items arrive one per cycle on a push port and are held in a small circular store. Once enough items have collected, the block raises a burst request toward the memory-side engine. The memory side then returns a one-cycle grant, and the block delivers exactly the requested number of items on consecutive cycles.

Two 2-bit configuration inputs set the behaviour. One chooses the fill fraction that triggers a request. The other chooses the burst length. A 3-bit status code reports the fill level in quarter bands, with separate codes for empty and full.

At the end of a block, a flush pulse switches the block to draining. In that mode every remaining item is offered as a single-beat request until the store is empty, and then the block returns to normal operation. A push that arrives while the store is full is discarded and sets a sticky overrun flag.

Top module: `thr_burst_fifo`

## Requirements
- R1: The trigger level is DEPTH*(thr_sel+1)/4. With the default DEPTH of 16 this gives 4, 8, 12 and 16 for thr_sel 0, 1, 2 and 3. Outside flush mode, burst_req is high only while the fill count is at or above this level.
- R2: burst_sel selects the burst length: 0 is 1 beat, 1 is 4 beats, 2 is 8 beats and 3 is 16 beats. Outside flush mode, req_beats shows this length, and a request also needs the fill count to be at least the burst length.
- R3: A cycle with burst_req and burst_grant both high is a grant. Starting on the following cycle, pop_valid is high for exactly req_beats consecutive cycles, and pop_data presents the items in push order. A grant while burst_req is low has no effect.
- R4: level_code is 4 when the store is empty and 5 when it is full. Otherwise it is 0 below a quarter, 1 from a quarter to below half, 2 from half to below three quarters, and 3 from three quarters to below full.
- R5: A flush pulse enters flush mode on the next clock. In flush mode, burst_req is high whenever the store is not empty and no burst is running, and req_beats is 1. The mode ends once the store is empty and idle.
- R6: A push while level_code is 5 is discarded and sets overrun. overrun stays high until reset.
- R7: After reset, level_code is 4 and burst_req, pop_valid and overrun are low.
- R8: burst_req is low in every cycle in which pop_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Push one item this cycle |
| push_data | input | W | Item to push |
| flush | input | 1 | Pulse: drain the remainder as single beats |
| thr_sel | input | 2 | Trigger fraction select |
| burst_sel | input | 2 | Burst length select |
| burst_grant | input | 1 | Grant from the memory side |
| burst_req | output | 1 | Burst request |
| req_beats | output | CW (5) | Length of the requested burst |
| pop_valid | output | 1 | Item on pop_data is released this cycle |
| pop_data | output | W | Released item |
| level_code | output | 3 | Encoded fill band |
| overrun | output | 1 | Sticky dropped-push flag |

## Verification
The bench checks the point where a request must wait for the burst length even though the fraction threshold has already been passed. A design that compared the fill count only against the threshold would request an 8-beat burst while holding just a few items. The bench also pushes into a full store and then drains it. A design that overwrote the oldest item, or let the overrun flag clear, would show the wrong data order or a lost flag. It counts the beats released per grant, sends a stray grant while no request is pending, and checks that flush ends cleanly. A design that stayed in flush mode would keep requesting single beats under an unmet threshold.

// File: rtl/tbf_pkg.sv
package tbf_pkg;

  // Fill level that arms a request, for a 2-bit fraction select.
  function automatic int thr_level(input int sel, input int depth);
    return (depth * (sel + 1)) / 4;
  endfunction

  // Burst length in beats for a 2-bit length select.
  function automatic int burst_len(input int sel);
    return (sel == 0) ? 1 : (1 << (sel + 1));
  endfunction

  // Quarter-band status code for a fill count.
  function automatic int band_code(input int cnt, input int depth);
    if (cnt == 0) return 4;
    if (cnt >= depth) return 5;
    return (cnt * 4) / depth;
  endfunction

endpackage

// File: rtl/tbf_store.sv
module tbf_store #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + AW'(1);
      if (rd_en) rd_ptr <= rd_ptr + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/tbf_ctrl.sv
module tbf_ctrl #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [1:0]    thr_sel,
  input  logic [1:0]    burst_sel,
  input  logic          flush,
  input  logic          grant,
  output logic          burst_req,
  output logic [CW-1:0] req_beats,
  output logic          pop_en,
  output logic          grant_take
);

  logic          busy, flush_mode;
  logic [CW-1:0] beats_left;
  logic [CW-1:0] thr_lvl, blen;
  logic          armed;

  assign thr_lvl = CW'(tbf_pkg::thr_level(int'(thr_sel), DEPTH));
  assign blen    = CW'(tbf_pkg::burst_len(int'(burst_sel)));
  assign armed   = (count >= thr_lvl) && (count >= blen);

  assign burst_req  = !busy && (flush_mode ? (count != '0) : armed);
  assign req_beats  = flush_mode ? CW'(1) : blen;
  assign grant_take = burst_req && grant;
  assign pop_en     = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_mode <= 1'b0;
    end else if (flush) begin
      flush_mode <= 1'b1;
    end else if (!busy && count == '0) begin
      flush_mode <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      beats_left <= '0;
    end else if (grant_take) begin
      busy       <= 1'b1;
      beats_left <= req_beats;
    end else if (busy) begin
      beats_left <= beats_left - CW'(1);
      if (beats_left == CW'(1)) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/tbf_level.sv
module tbf_level #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  output logic [2:0]    code,
  output logic          is_full
);

  assign code    = 3'(tbf_pkg::band_code(int'(count), DEPTH));
  assign is_full = (count == CW'(DEPTH));

endmodule

// File: rtl/thr_burst_fifo.sv
module thr_burst_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [W-1:0]  push_data,
  input  logic          flush,
  input  logic [1:0]    thr_sel,
  input  logic [1:0]    burst_sel,
  input  logic          burst_grant,
  output logic          burst_req,
  output logic [CW-1:0] req_beats,
  output logic          pop_valid,
  output logic [W-1:0]  pop_data,
  output logic [2:0]    level_code,
  output logic          overrun
);

  logic [CW-1:0] count;
  logic          is_full;
  logic          push_ok, push_drop;
  logic          pop_fire, grant_take;

  assign push_ok   = push_valid && !is_full;
  assign push_drop = push_valid && is_full;

  tbf_store #(.W(W), .DEPTH(DEPTH)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push_ok),
    .wr_data (push_data),
    .rd_en   (pop_fire),
    .rd_data (pop_data),
    .count   (count)
  );

  tbf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .count      (count),
    .thr_sel    (thr_sel),
    .burst_sel  (burst_sel),
    .flush      (flush),
    .grant      (burst_grant),
    .burst_req  (burst_req),
    .req_beats  (req_beats),
    .pop_en     (pop_fire),
    .grant_take (grant_take)
  );

  tbf_level #(.DEPTH(DEPTH)) level_i (
    .count   (count),
    .code    (level_code),
    .is_full (is_full)
  );

  assign pop_valid = pop_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overrun <= 1'b0;
    else if (push_drop) overrun <= 1'b1;
  end

endmodule

// File: rtl/tbf_checker.sv
module tbf_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          burst_req,
  input logic [CW-1:0] req_beats,
  input logic          pop_valid,
  input logic [2:0]    level_code,
  input logic          overrun,
  input logic          grant_take
);

  logic [CW:0]   run_len;
  logic [CW-1:0] exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      exp_len <= '0;
    end else begin
      run_len <= pop_valid ? run_len + (CW+1)'(1) : '0;
      if (grant_take) exp_len <= req_beats;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (level_code == 3'd5 && push_valid) |=> overrun); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R6
  AST_NO_REQ_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> !burst_req); // R8
  AST_REQ_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> level_code != 3'd4); // R1
  AST_BEATS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> ($countones(req_beats) == 1 && req_beats <= CW'(16))); // R2
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    level_code <= 3'd5); // R4
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pop_valid) |-> run_len == (CW+1)'(exp_len)); // R3

endmodule

bind thr_burst_fifo tbf_checker #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .burst_req  (burst_req),
  .req_beats  (req_beats),
  .pop_valid  (pop_valid),
  .level_code (level_code),
  .overrun    (overrun),
  .grant_take (grant_take)
);

// File: tb/thr_burst_fifo_tb_top.sv
module thr_burst_fifo_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int DP = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 1'b0;
  logic [W-1:0] push_data = '0;
  logic       flush = 1'b0;
  logic [1:0] thr_sel = 2'd0;
  logic [1:0] burst_sel = 2'd0;
  logic       burst_grant = 1'b0;
  logic       burst_req;
  logic [4:0] req_beats;
  logic       pop_valid;
  logic [W-1:0] pop_data;
  logic [2:0] level_code;
  logic       overrun;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model_q[$];
  logic [W-1:0] next_val = 8'h10;

  always #(CLK_PERIOD/2) clk = ~clk;

  thr_burst_fifo #(.W(W), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .flush(flush), .thr_sel(thr_sel), .burst_sel(burst_sel),
    .burst_grant(burst_grant), .burst_req(burst_req), .req_beats(req_beats),
    .pop_valid(pop_valid), .pop_data(pop_data), .level_code(level_code),
    .overrun(overrun)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int n);
    if (n == 0) return 4;
    if (n == DP) return 5;
    if (n < DP/4) return 0;
    if (n < DP/2) return 1;
    if (n < 3*DP/4) return 2;
    return 3;
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      push_valid = 1'b1;
      push_data  = next_val;
      if (model_q.size() < DP) model_q.push_back(next_val);
      next_val++;
      cyc();
      push_valid = 1'b0;
    end
  endtask

  task automatic grant_burst(input string tag, input int n);
    check({tag, " req"}, int'(burst_req), 1);
    check({tag, " beats"}, int'(req_beats), n);
    burst_grant = 1'b1;
    cyc();
    burst_grant = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] e;
      e = model_q.pop_front();
      check({tag, " R3 pop_valid"}, int'(pop_valid), 1);
      check({tag, " R3 data"}, int'(pop_data), int'(e));
      check({tag, " R8 req low"}, int'(burst_req), 0);
      cyc();
    end
    check({tag, " R3 burst end"}, int'(pop_valid), 0);
  endtask

  task automatic t_reset();
    check("R7 code", int'(level_code), 4);
    check("R7 req", int'(burst_req), 0);
    check("R7 pop", int'(pop_valid), 0);
    check("R7 overrun", int'(overrun), 0);
  endtask

  task automatic t_threshold();
    thr_sel = 2'd1; burst_sel = 2'd0;
    push_n(7);
    check("R1 below half", int'(burst_req), 0);
    check("R4 code 7", int'(level_code), exp_code(7));
    push_n(1);
    check("R4 code 8", int'(level_code), exp_code(8));
    grant_burst("R1 half single", 1);
    check("R1 seven below half", int'(burst_req), 0);
    thr_sel = 2'd0;
    cyc();
    for (int i = 0; i < 4; i++) grant_burst("R1 quarter single", 1);
    check("R1 three below quarter", int'(burst_req), 0);
    check("R4 code 3", int'(level_code), exp_code(3));
    flush = 1'b1; cyc(); flush = 1'b0;
    for (int i = 0; i < 3; i++) grant_burst("R5 flush", 1);
    cyc();
    check("R5 empty after flush", int'(level_code), 4);
    check("R5 no req when empty", int'(burst_req), 0);
  endtask

  task automatic t_bursts();
    thr_sel = 2'd0; burst_sel = 2'd1;
    cyc();
    push_n(3);
    check("R1 below quarter", int'(burst_req), 0);
    push_n(1);
    grant_burst("R2 burst4", 4);
    burst_sel = 2'd2;
    push_n(7);
    check("R2 waits for 8", int'(burst_req), 0);
    check("R4 code 7", int'(level_code), exp_code(7));
    push_n(1);
    grant_burst("R2 burst8", 8);
    check("R4 empty", int'(level_code), 4);
  endtask

  task automatic t_full();
    thr_sel = 2'd3; burst_sel = 2'd3;
    push_n(15);
    check("R4 code 15", int'(level_code), exp_code(15));
    check("R1 below full", int'(burst_req), 0);
    push_n(1);
    check("R4 code full", int'(level_code), 5);
    check("R6 no overrun yet", int'(overrun), 0);
    push_n(1);
    check("R6 overrun set", int'(overrun), 1);
    check("R6 still full", int'(level_code), 5);
    grant_burst("R2 burst16", 16);
    check("R4 empty after 16", int'(level_code), 4);
    check("R6 sticky", int'(overrun), 1);
  endtask

  task automatic t_stray_grant();
    burst_grant = 1'b1; cyc(); burst_grant = 1'b0;
    check("R3 stray grant pop", int'(pop_valid), 0);
    cyc();
    check("R3 stray grant pop later", int'(pop_valid), 0);
    check("R3 stray grant code", int'(level_code), 4);
  endtask

  task automatic t_flush_partial();
    thr_sel = 2'd2; burst_sel = 2'd2;
    push_n(5);
    check("R1 below 3q", int'(burst_req), 0);
    flush = 1'b1; cyc(); flush = 1'b0;
    for (int i = 0; i < 5; i++) grant_burst("R5 flush single", 1);
    cyc();
    cyc();
    push_n(5);
    check("R5 normal after flush", int'(burst_req), 0);
    check("R4 code 5", int'(level_code), exp_code(5));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_threshold();
    t_bursts();
    t_full();
    t_stray_grant();
    t_flush_partial();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule